// File: doc/BRIEF.md
# Vectorized Stride Prefetch Generator

This block is given one striding load, described by a base address and a signed stride. It turns that load into a burst of independent prefetch addresses. The load is treated as a vector of eight lanes. The vector is then unrolled over a chosen number of rounds, from one to eight, so a single trigger yields up to 64 requests. The request with lane `i` and round `r` targets `base + (8*r + i + 1) * stride`. Requests leave in order, one lane per beat, over a valid/ready output.

A trigger is taken only while the block is idle. Inside the block, the whole vector is held as one descriptor: the stride, the last-round index and a single running address. No per-lane state is kept. When the final lane of the final round is accepted, a one-cycle completion pulse follows. An abort input drops any lanes still outstanding and produces no completion pulse.

Top module: `vec_stride_prefetch`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `busy`, `req_valid` and `chain_done` are all 0.
- R2: If `trig_valid` is high on a clock edge while `busy` is 0, then from the next cycle `busy` and `req_valid` are 1, `req_addr` equals `trig_base + trig_stride`, and `req_lane` and `req_round` are both 0.
- R3: The k-th accepted request (k counted from 0) carries `req_addr = base + (k+1)*stride`, with `req_lane = k mod 8` and `req_round = k div 8`. Lanes ascend within a round, and rounds ascend.
- R4: The number of rounds is `trig_rounds`, with 0 taken as 1 and any value from 9 to 15 taken as 8. Exactly 8 × rounds requests are accepted, after which `busy` and `req_valid` return to 0.
- R5: A request advances only on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` stays high and `req_addr` does not change.
- R6: `chain_done` goes high for exactly one cycle: the cycle after the last request is accepted. In that same cycle `busy` is already 0.
- R7: A trigger that arrives while `busy` is 1 is ignored. The running sequence continues with its original base, stride and round count.
- R8: Addresses wrap modulo 2^32, and `trig_stride` is read as a signed two's-complement value, so negative strides produce descending addresses.
- R9: If `abort` is high on a clock edge while `busy` is 1, the next cycle has `busy`, `req_valid` and `chain_done` all at 0, and no completion pulse follows. `abort` has no effect while idle, so a trigger on the same edge is still accepted.
- R10: A trigger that arrives in the same cycle as `chain_done` is accepted, because the block is already idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_valid | input | 1 | Trigger strobe for a new striding load |
| trig_base | input | 32 | Base address of the load |
| trig_stride | input | 32 | Signed stride in bytes |
| trig_rounds | input | 4 | Requested number of unrolled rounds (clamped to 1..8) |
| abort | input | 1 | Drop the remaining lanes and return to idle |
| req_ready | input | 1 | Consumer accepts the current request |
| req_valid | output | 1 | A prefetch request is offered |
| req_addr | output | 32 | Prefetch address |
| req_lane | output | 3 | Lane index of the request |
| req_round | output | 3 | Round index of the request |
| busy | output | 1 | A sequence is in progress |
| chain_done | output | 1 | One-cycle pulse after the last request is accepted |

## Verification
The bench sweeps all sixteen round-count codes. Each code is run with a positive and a negative stride, and under three back-pressure patterns. This exposes a clamp that is off by one, which would emit 0 or 72 requests or stop a round early. It also exposes an address that moves during a stall, which would show up as skipped or repeated offsets. One base sits near the top of the address space, and one stride is negative, so an address path that is too narrow or an unsigned stride gives wrong wrapped values. The remaining runs target the control corners. A mid-run trigger that gets re-latched corrupts the rest of the sequence. An abort that still pulses completion, or that blocks a trigger while idle, is caught. So is a completion cycle that refuses a back-to-back trigger.

// File: rtl/vpf_pkg.sv
// Package: shared widths and the clamp rule for the vectorized stride
// prefetch generator. Assumes a 32-bit byte address space.
package vpf_pkg;

    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    // Turn a requested round count into a last-round index; 0 means one round.
    function automatic int unsigned last_round_idx(input int unsigned req,
                                                   input int unsigned max_rounds);
        if (req == 0)
            return 0;
        else if (req > max_rounds)
            return max_rounds - 1;
        else
            return req - 1;
    endfunction

endpackage

// File: rtl/vpf_launch.sv
// Module: vpf_launch
// Accepts a trigger while the block is idle and captures the single vector
// descriptor that the whole run uses: the stride and the clamped last-round
// index. Assumes idle_i is low for the whole of a run.
module vpf_launch
    import vpf_pkg::*;
#(
    parameter int MAX_ROUNDS = 8,
    parameter int RCNT_W     = 4,
    localparam int RIDX_W    = (MAX_ROUNDS > 1) ? $clog2(MAX_ROUNDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              trig_valid_i,
    input  addr_t             trig_stride_i,
    input  logic [RCNT_W-1:0] trig_rounds_i,
    output logic              take_o,
    output addr_t             stride_q_o,
    output logic [RIDX_W-1:0] last_round_o
);

    logic [RIDX_W-1:0] last_round_d;

    // Take a trigger only while nothing is in flight.
    assign take_o = trig_valid_i && idle_i;

    // Clamp the requested round count to 1..MAX_ROUNDS as a last index.
    always_comb begin
        last_round_d = RIDX_W'(last_round_idx(int'(trig_rounds_i), MAX_ROUNDS));
    end

    // Hold the descriptor for the whole run; reload only on an accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stride_q_o   <= '0;
            last_round_o <= '0;
        end else if (take_o) begin
            stride_q_o   <= trig_stride_i;
            last_round_o <= last_round_d;
        end
    end

endmodule

// File: rtl/vpf_walker.sv
// Module: vpf_walker
// Steps through lane and round indices for one vector run, one lane per
// accepted beat, and produces the busy flag and the completion pulse.
// Assumes take_i arrives only while busy_o is low.
module vpf_walker #(
    parameter int LANES      = 8,
    parameter int MAX_ROUNDS = 8,
    localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int RIDX_W    = (MAX_ROUNDS > 1) ? $clog2(MAX_ROUNDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [RIDX_W-1:0] last_round_i,
    input  logic              ready_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic              fire_o,
    output logic [LANE_W-1:0] lane_o,
    output logic [RIDX_W-1:0] round_o,
    output logic              done_o
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    logic end_of_round;
    logic end_of_run;

    // A beat is accepted when a run is active, the consumer is ready and no abort is pending.
    assign fire_o       = busy_o && ready_i && !abort_i;
    assign end_of_round = (lane_o == LAST_LANE);
    assign end_of_run   = end_of_round && (round_o == last_round_i);

    // Sequencer state: busy flag plus lane and round counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            lane_o  <= '0;
            round_o <= '0;
        end else if (busy_o) begin
            if (abort_i) begin
                busy_o <= 1'b0;
            end else if (fire_o) begin
                if (end_of_run) begin
                    busy_o <= 1'b0;
                end else if (end_of_round) begin
                    lane_o  <= '0;
                    round_o <= round_o + 1'b1;
                end else begin
                    lane_o <= lane_o + 1'b1;
                end
            end
        end else if (take_i) begin
            busy_o  <= 1'b1;
            lane_o  <= '0;
            round_o <= '0;
        end
    end

    // Pulse completion on the cycle after the final beat is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= 1'b0;
        else
            done_o <= fire_o && end_of_run;
    end

endmodule

// File: rtl/vpf_addr.sv
// Module: vpf_addr
// Keeps one running address for the whole vector run. It loads base+stride
// when a trigger is taken and adds the stride on each accepted beat, so
// lane addresses never need a multiplier. Assumes load_i and step_i are
// never high on the same edge.
module vpf_addr
    import vpf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  addr_t base_i,
    input  addr_t load_stride_i,
    input  logic  step_i,
    input  addr_t stride_i,
    output addr_t addr_o
);

    // Running address; sums wrap modulo 2^32, which also covers signed strides.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_o <= '0;
        else if (load_i)
            addr_o <= base_i + load_stride_i;
        else if (step_i)
            addr_o <= addr_o + stride_i;
    end

endmodule

// File: rtl/vec_stride_prefetch.sv
// Module: vec_stride_prefetch
// Top level. Expands one striding load into LANES x rounds prefetch
// addresses and offers them one lane per beat over valid/ready. Assumes
// the consumer holds req_ready meaningful only while req_valid is high.
module vec_stride_prefetch
    import vpf_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int MAX_ROUNDS = 8,
    parameter int RCNT_W     = 4,
    localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int RIDX_W    = (MAX_ROUNDS > 1) ? $clog2(MAX_ROUNDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [31:0]       trig_base,
    input  logic [31:0]       trig_stride,
    input  logic [RCNT_W-1:0] trig_rounds,
    input  logic              abort,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [31:0]       req_addr,
    output logic [LANE_W-1:0] req_lane,
    output logic [RIDX_W-1:0] req_round,
    output logic              busy,
    output logic              chain_done
);

    logic              take;
    logic              fire;
    addr_t             stride_q;
    logic [RIDX_W-1:0] last_round;

    vpf_launch #(
        .MAX_ROUNDS (MAX_ROUNDS),
        .RCNT_W     (RCNT_W)
    ) u_launch (
        .clk           (clk),
        .rst_n         (rst_n),
        .idle_i        (!busy),
        .trig_valid_i  (trig_valid),
        .trig_stride_i (trig_stride),
        .trig_rounds_i (trig_rounds),
        .take_o        (take),
        .stride_q_o    (stride_q),
        .last_round_o  (last_round)
    );

    vpf_walker #(
        .LANES      (LANES),
        .MAX_ROUNDS (MAX_ROUNDS)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .last_round_i (last_round),
        .ready_i      (req_ready),
        .abort_i      (abort),
        .busy_o       (busy),
        .fire_o       (fire),
        .lane_o       (req_lane),
        .round_o      (req_round),
        .done_o       (chain_done)
    );

    vpf_addr u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (take),
        .base_i        (trig_base),
        .load_stride_i (trig_stride),
        .step_i        (fire),
        .stride_i      (stride_q),
        .addr_o        (req_addr)
    );

    // A request is offered exactly while a run is active.
    assign req_valid = busy;

endmodule

// File: rtl/vpf_chk.sv
// Module: vpf_chk
// Protocol checker bound to vec_stride_prefetch. It watches the handshake,
// the completion pulse, abort handling and how the stored stride is held.
module vpf_chk #(
    parameter int LANES  = 8,
    parameter int LANE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_valid,
    input logic              abort,
    input logic              req_ready,
    input logic              req_valid,
    input logic [31:0]       req_addr,
    input logic [LANE_W-1:0] req_lane,
    input logic              busy,
    input logic              chain_done,
    input logic [31:0]       stride_q
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !chain_done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> !busy && !req_valid);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !abort) |=> (req_valid && $stable(req_addr)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !abort && (req_lane != LANE_W'(LANES - 1)))
        |=> (req_valid && (req_addr == $past(req_addr) + stride_q)));

    // R9
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !chain_done));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_valid) |=> $stable(stride_q));

endmodule

bind vec_stride_prefetch vpf_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_vpf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .abort      (abort),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_lane   (req_lane),
    .busy       (busy),
    .chain_done (chain_done),
    .stride_q   (stride_q)
);

// File: tb/test_vec_stride_prefetch.sv
`timescale 1ns/1ps
// Bench: sweeps every round-count code, two stride/base pairs and three
// back-pressure patterns, then targets abort, busy-trigger and back-to-back corners.
module test_vec_stride_prefetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_valid = 1'b0;
    logic [31:0] trig_base = '0;
    logic [31:0] trig_stride = '0;
    logic [3:0]  trig_rounds = '0;
    logic        abort = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [2:0]  req_lane;
    logic [2:0]  req_round;
    logic        busy;
    logic        chain_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    vec_stride_prefetch i_vec_stride_prefetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_valid  (trig_valid),
        .trig_base   (trig_base),
        .trig_stride (trig_stride),
        .trig_rounds (trig_rounds),
        .abort       (abort),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_lane    (req_lane),
        .req_round   (req_round),
        .busy        (busy),
        .chain_done  (chain_done)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: all requirements, got cycle %0d exp < 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit cond, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: got %h exp %h", req, act, exp);
        end
    endtask

    function automatic bit pick_ready(input int mode, input int t);
        case (mode)
            0: return 1'b1;
            1: return t[0];
            default: return ((t * 7 + 3) % 5) != 0;
        endcase
    endfunction

    // One full run: checks the first offer, every accepted address, the count and the pulse.
    task automatic run_chain(input logic [31:0] b, input logic [31:0] s, input logic [3:0] r,
                             input int mode, input bit poke, input bit b2b);
        int nr;
        int want;
        int k = 0;
        int t = 0;
        bit ok = 1'b1;
        logic [31:0] exp_a;
        logic [31:0] bad_a = '0;
        logic [31:0] bad_e = '0;
        nr   = (r == 0) ? 1 : ((r > 8) ? 8 : int'(r));
        want = nr * 8;
        @(negedge clk);
        trig_valid = 1'b1; trig_base = b; trig_stride = s; trig_rounds = r;
        @(negedge clk);
        trig_valid = 1'b0;
        // R2 first offer
        check(busy && req_valid && req_addr == b + s && req_lane == 0 && req_round == 0,
              "R2 first request", req_addr, b + s);
        while (k < want && t < 4000) begin
            req_ready = pick_ready(mode, t);
            if (poke && k >= 3 && k < 6) begin
                trig_valid = 1'b1; trig_base = ~b; trig_stride = s + 32'd12; trig_rounds = 4'd1;
            end else begin
                trig_valid = 1'b0;
            end
            if (!req_valid) begin
                if (ok) begin bad_a = 32'(k); bad_e = 32'(want); end
                ok = 1'b0;
            end else if (req_ready) begin
                exp_a = b + 32'(k + 1) * s;
                if (req_addr !== exp_a || req_lane != 3'(k % 8) || req_round != 3'(k / 8)) begin
                    if (ok) begin bad_a = req_addr; bad_e = exp_a; end
                    ok = 1'b0;
                end
                k++;
            end
            @(negedge clk);
            t++;
        end
        req_ready = 1'b0;
        trig_valid = 1'b0;
        // R3 R5 R8 address sequence under back-pressure (R7 when poked mid-run)
        check(ok, poke ? "R7 R3 sequence with busy trigger" : "R3 R5 R8 address sequence",
              bad_a, bad_e);
        // R4 R6 count and completion pulse
        check(chain_done && !busy && !req_valid && k == want,
              "R4 R6 count and done", 32'(k), 32'(want));
        if (b2b) begin
            trig_valid = 1'b1; trig_base = 32'h40; trig_stride = 32'h8; trig_rounds = 4'd1;
        end
        @(negedge clk);
        trig_valid = 1'b0;
        check(!chain_done, "R6 single pulse", {31'b0, chain_done}, 32'h0);
        if (b2b) begin
            // R10 trigger during the done cycle
            check(busy && req_addr == 32'h48, "R10 back-to-back trigger", req_addr, 32'h48);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
        end
    endtask

    initial begin
        // R1 reset values
        repeat (3) @(negedge clk);
        check(!busy && !req_valid && !chain_done, "R1 during reset",
              {29'b0, busy, req_valid, chain_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid && !chain_done, "R1 after reset",
              {29'b0, busy, req_valid, chain_done}, 32'h0);

        // R4 R8 sweep: every round code x two stride/base pairs x three ready patterns
        for (int r = 0; r < 16; r++) begin
            for (int m = 0; m < 3; m++) begin
                run_chain(32'h0000_1000, 32'h0000_0040, 4'(r), m, 1'b0, 1'b0);
                run_chain(32'hFFFF_FF00, 32'hFFFF_FFF4, 4'(r), m, 1'b0, 1'b0);
            end
        end
        // R8 forward wrap past 2^32
        run_chain(32'hFFFF_FFE0, 32'h0000_0010, 4'd2, 0, 1'b0, 1'b0);

        // R7 triggers while busy
        run_chain(32'h0002_0000, 32'h0000_0100, 4'd3, 2, 1'b1, 1'b0);
        // R10 back-to-back
        run_chain(32'h0003_0000, 32'h0000_0004, 4'd1, 0, 1'b0, 1'b1);

        // R9 abort mid-run
        @(negedge clk);
        trig_valid = 1'b1; trig_base = 32'h5000; trig_stride = 32'h20; trig_rounds = 4'd8;
        @(negedge clk);
        trig_valid = 1'b0; req_ready = 1'b1;
        repeat (3) @(negedge clk);
        req_ready = 1'b0; abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(!busy && !req_valid && !chain_done, "R9 abort drops run",
              {29'b0, busy, req_valid, chain_done}, 32'h0);
        repeat (2) @(negedge clk);
        check(!chain_done && !busy, "R9 no pulse after abort", {31'b0, chain_done}, 32'h0);

        // R9 abort while idle does not block a trigger
        abort = 1'b1; trig_valid = 1'b1;
        trig_base = 32'h7000; trig_stride = 32'hFFFF_FFF0; trig_rounds = 4'd1;
        @(negedge clk);
        abort = 1'b0; trig_valid = 1'b0;
        check(busy && req_addr == 32'h6FF0, "R9 idle abort ignored", req_addr, 32'h6FF0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule